// File: doc/BRIEF.md
# Supply Undervoltage Reset Supervisor

This block turns two digitised supply-level flags into an active-low system reset. One flag says the regulator output is under the lower (detection) threshold. The other says it is over the higher (recovery) threshold. Because the two thresholds differ, the flags form a hysteresis band. The supervisor trusts a low supply only after the detection flag has held for a minimum number of cycles. It trusts a recovered supply only after the recovery flag has held without a break for a much longer reset time.

A force-low request from the mode controller overrides both flags. The mode controller raises it while the node is powered off or asleep. While the request is present, reset is low and the supervisor forgets any good-supply state it held. Once the request drops, the full release time must pass again.

While reset is low, the host's bus-switch control and high-side switch controls are masked to logic low. No actuator can act on a command from a host that is still held in reset.

Top module: `uv_reset_supervisor`

## Requirements
- R1: While the power-on reset input `por_n` is low, `rst_out_n`, `vcc_ok`, `sw_open` and every bit of `hs_on` are 0. After `por_n` rises, `vcc_ok` stays 0 until a full release sequence (R2) completes.
- R2: While `vcc_ok` is 0 and `force_low` is 0, `vcc_ok` rises at the clock edge that samples `uv_above` high for the REL_CYCLES-th consecutive time. No earlier edge raises it. `rst_out_n` then reads 1.
- R3: If `uv_above` is sampled low during the release count, the count restarts from zero. A further REL_CYCLES consecutive high samples are then needed.
- R4: While `vcc_ok` is 1, it falls at the clock edge that samples `uv_below` high for the DET_CYCLES-th consecutive time. `rst_out_n` reads 0 from then on.
- R5: A run of `uv_below` high that is shorter than DET_CYCLES samples leaves `vcc_ok` at 1.
- R6: Hysteresis. With both flags low (supply inside the band), `vcc_ok` holds its value indefinitely, whether that value is 0 or 1.
- R7: While `force_low` is 1, `rst_out_n` is 0 in the same cycle, whatever the flags show. `vcc_ok` is 0 from the next edge on. No release count advances until `force_low` returns to 0, after which R2 applies in full.
- R8: While `rst_out_n` is 0, `sw_open` and all bits of `hs_on` are 0. While it is 1, `sw_open` equals `sw_open_req` and `hs_on` equals `hs_on_req`, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| uv_below | input | 1 | Supply is under the detection threshold |
| uv_above | input | 1 | Supply is over the recovery threshold |
| force_low | input | 1 | Mode controller request to hold reset low (off or sleep) |
| sw_open_req | input | 1 | Host request to open the bus pass switch |
| hs_on_req | input | NUM_HS | Host requests to turn on the high-side outputs |
| rst_out_n | output | 1 | System reset, active low |
| vcc_ok | output | 1 | Supply confirmed good by the filters |
| sw_open | output | 1 | Masked bus-switch open control |
| hs_on | output | NUM_HS | Masked high-side output controls |

## Verification
The hardest state to reach from the ports is a release count broken one sample before it would finish. This must be followed by a count that does finish, with a forced-low period in between, so that no stale count survives into the next attempt. Directed sequences break the recovery flag at a mid-count point and at exactly REL_CYCLES-1 samples. They also hold `force_low` over a long recovered run. Seeded random segments of low, in-band and high supply, with occasional force requests, are compared cycle by cycle against a reference model built from the requirements.

// File: rtl/uv_reset_supervisor.sv
module uv_reset_supervisor #(
  parameter int DET_CYCLES = 8,
  parameter int REL_CYCLES = 64,
  parameter int NUM_HS     = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              uv_below,
  input  logic              uv_above,
  input  logic              force_low,
  input  logic              sw_open_req,
  input  logic [NUM_HS-1:0] hs_on_req,
  output logic              rst_out_n,
  output logic              vcc_ok,
  output logic              sw_open,
  output logic [NUM_HS-1:0] hs_on
);

  localparam int DW = (DET_CYCLES > 1) ? $clog2(DET_CYCLES) : 1;
  localparam int RW = (REL_CYCLES > 1) ? $clog2(REL_CYCLES) : 1;
  localparam logic [DW-1:0] DET_LAST = DW'(DET_CYCLES - 1);
  localparam logic [RW-1:0] REL_LAST = RW'(REL_CYCLES - 1);

  logic          ok;
  logic [DW-1:0] det_cnt;
  logic [RW-1:0] rel_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ok      <= 1'b0;
      det_cnt <= '0;
      rel_cnt <= '0;
    end else if (force_low) begin
      ok      <= 1'b0;
      det_cnt <= '0;
      rel_cnt <= '0;
    end else if (ok) begin
      rel_cnt <= '0;
      if (!uv_below) begin
        det_cnt <= '0;
      end else if (det_cnt == DET_LAST) begin
        ok      <= 1'b0;
        det_cnt <= '0;
      end else begin
        det_cnt <= det_cnt + DW'(1);
      end
    end else begin
      det_cnt <= '0;
      if (!uv_above) begin
        rel_cnt <= '0;
      end else if (rel_cnt == REL_LAST) begin
        ok      <= 1'b1;
        rel_cnt <= '0;
      end else begin
        rel_cnt <= rel_cnt + RW'(1);
      end
    end
  end

  assign vcc_ok    = ok;
  assign rst_out_n = ok & ~force_low;
  assign sw_open   = rst_out_n & sw_open_req;
  assign hs_on     = rst_out_n ? hs_on_req : '0;

  // The rise of the good flag must follow a high recovery sample with no force request.
  assert_release_cause_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(vcc_ok) |-> ($past(uv_above) && !$past(force_low)));

  // The fall needs a low-supply sample or a force request.
  assert_detect_cause_R4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(vcc_ok) |-> ($past(uv_below) || $past(force_low)));

  // Inside the band a good supply stays good.
  assert_band_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (vcc_ok && !uv_below && !force_low) |=> vcc_ok);

  // Inside the band a bad supply stays bad.
  assert_band_stay_low_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!vcc_ok && !uv_above) |=> !vcc_ok);

  assert_force_low_R7: assert property (@(posedge clk) disable iff (!por_n)
    force_low |-> (!rst_out_n ##1 !vcc_ok));

  assert_mask_R8: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out_n |-> (!sw_open && hs_on == '0));

  assert_pass_R8: assert property (@(posedge clk) disable iff (!por_n)
    rst_out_n |-> (sw_open == sw_open_req && hs_on == hs_on_req));

  always_comb begin
    if (!por_n) assert_por_low_R1: assert (!rst_out_n && !vcc_ok);
  end

endmodule

// File: tb/uv_reset_supervisor_tb.sv
module uv_reset_supervisor_tb;
  localparam int DET = 8;
  localparam int REL = 64;
  localparam int NH  = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic uv_below = 1'b0, uv_above = 1'b0, force_low = 1'b0, sw_open_req = 1'b0;
  logic [NH-1:0] hs_on_req = '0;
  logic rst_out_n, vcc_ok, sw_open;
  logic [NH-1:0] hs_on;

  int checks = 0, failures = 0;
  bit done = 0;
  string phase = "R1";

  // Reference model state, built from the requirements.
  bit m_ok = 0;
  int m_det = 0, m_rel = 0;

  always #2 clk = ~clk;

  uv_reset_supervisor #(.DET_CYCLES(DET), .REL_CYCLES(REL), .NUM_HS(NH)) u_dut (
    .clk(clk), .por_n(por_n), .uv_below(uv_below), .uv_above(uv_above),
    .force_low(force_low), .sw_open_req(sw_open_req), .hs_on_req(hs_on_req),
    .rst_out_n(rst_out_n), .vcc_ok(vcc_ok), .sw_open(sw_open), .hs_on(hs_on));

  function automatic bit exp_rst();
    return m_ok && !force_low && por_n;
  endfunction

  function automatic logic [NH-1:0] exp_hs();
    return exp_rst() ? hs_on_req : '0;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_tick();
    if (!por_n || force_low) begin
      m_ok = 0; m_det = 0; m_rel = 0;
    end else if (m_ok) begin
      m_rel = 0;
      if (uv_below) begin
        m_det++;
        if (m_det == DET) begin m_ok = 0; m_det = 0; end
      end else m_det = 0;
    end else begin
      m_det = 0;
      if (uv_above) begin
        m_rel++;
        if (m_rel == REL) begin m_ok = 1; m_rel = 0; end
      end else m_rel = 0;
    end
  endtask

  task automatic check_all();
    check_eq(phase, "vcc_ok", int'(vcc_ok), int'(m_ok));
    check_eq(phase, "rst_out_n", int'(rst_out_n), int'(exp_rst()));
    check_eq(phase, "sw_open", int'(sw_open), int'(exp_rst() && sw_open_req));
    check_eq(phase, "hs_on", int'(hs_on), int'(exp_hs()));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_tick();
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic level(int sel);
    uv_below = (sel == 0);
    uv_above = (sel == 2);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1: power-on state with host requests active.
    hs_on_req = '1; sw_open_req = 1'b1; level(2);
    step(5);
    check_eq("R1", "rst_out_n in por", int'(rst_out_n), 0);
    check_eq("R8", "hs_on masked in por", int'(hs_on), 0);

    // R2: full release from power-on.
    @(negedge clk); por_n = 1'b1; phase = "R2";
    step(REL - 1);
    check_eq("R2", "vcc_ok one short", int'(vcc_ok), 0);
    step(1);
    check_eq("R2", "vcc_ok at count", int'(vcc_ok), 1);
    check_eq("R2", "rst_out_n released", int'(rst_out_n), 1);
    check_eq("R8", "hs_on passes", int'(hs_on), 7);

    // R5: blip one short of the detection time.
    phase = "R5"; level(0); step(DET - 1); level(1); step(1);
    check_eq("R5", "vcc_ok after blip", int'(vcc_ok), 1);

    // R6: in-band hold while good.
    phase = "R6"; step(100);
    check_eq("R6", "vcc_ok held in band", int'(vcc_ok), 1);

    // R4: detection at exactly DET samples.
    phase = "R4"; level(0); step(DET - 1);
    check_eq("R4", "vcc_ok one short", int'(vcc_ok), 1);
    step(1);
    check_eq("R4", "vcc_ok detected", int'(vcc_ok), 0);
    check_eq("R8", "sw_open masked", int'(sw_open), 0);

    // R6: in-band hold while bad.
    phase = "R6"; level(1); step(200);
    check_eq("R6", "vcc_ok stays low in band", int'(vcc_ok), 0);

    // R3: break mid count, then break at REL-1, then complete.
    phase = "R3"; level(2); step(40); level(1); step(1);
    level(2); step(REL - 1); level(1); step(1);
    check_eq("R3", "vcc_ok after late break", int'(vcc_ok), 0);
    level(2); step(REL - 1);
    check_eq("R3", "vcc_ok restart one short", int'(vcc_ok), 0);
    step(1);
    check_eq("R3", "vcc_ok after restart", int'(vcc_ok), 1);

    // R7: force overrides a good supply and needs a full release afterwards.
    phase = "R7"; force_low = 1'b1; #1;
    check_eq("R7", "rst_out_n same cycle", int'(rst_out_n), 0);
    check_eq("R8", "hs_on masked by force", int'(hs_on), 0);
    step(1);
    check_eq("R7", "vcc_ok next edge", int'(vcc_ok), 0);
    step(REL + 20);
    check_eq("R7", "no release under force", int'(vcc_ok), 0);
    force_low = 1'b0; step(REL - 1);
    check_eq("R7", "vcc_ok one short after force", int'(vcc_ok), 0);
    step(1);
    check_eq("R7", "vcc_ok after force", int'(vcc_ok), 1);

    // Random level segments mixed with force requests and host inputs.
    phase = "R2/R4 random";
    for (int s = 0; s < 300; s++) begin
      int len = 1 + ($urandom % 80);
      level($urandom % 3);
      force_low = (($urandom % 10) == 0);
      for (int c = 0; c < len; c++) begin
        sw_open_req = $urandom % 2;
        hs_on_req = NH'($urandom);
        step(1);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule